// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Cycle

This block is a small single-accumulator processor. Instructions and data sit together in one synchronous single-port word memory outside the block, and any location can hold either. Each 16-bit instruction word carries a 4-bit operation code in its upper bits and a 12-bit memory location in its lower bits. Every instruction passes through three phases: fetch, execute, and an interrupt check.

All memory traffic goes through two internal registers. The address register drives the memory address pins. The buffer register captures read data and drives the write data. The memory returns read data one clock after it sees the address, so every access spends a cycle setting the address, a cycle at the memory, and a cycle capturing the data. The fetched word moves into an instruction register and the program counter advances by one.

A single interrupt request input is latched into a pending flag. When an instruction finishes, a pending request is taken if interrupts are enabled. Taking it saves the program counter and accumulator into one level of shadow storage, disables interrupts, and jumps to a fixed handler location. A return instruction restores both saved values and re-enables interrupts. A request that arrives while the handler runs waits until the return.

Top module: `acc_cpu`

## Requirements
- R1: After reset the block fetches its first instruction from location 0, with halted low and no memory write active.
- R2: Bits [15:12] of an instruction hold the operation code and bits [11:0] hold a memory location. Code 0x1 copies the word at that location into the accumulator.
- R3: Code 0x5 adds the word at the location to the accumulator, and the sum wraps modulo 2^16.
- R4: Code 0x2 writes the accumulator to the location. While the write enable is high, the write data equals the accumulator.
- R5: Instructions run in sequence from consecutive locations. During each fetch the memory address equals the program counter.
- R6: When an instruction finishes with a request pending and interrupts enabled, the block saves the program counter and accumulator, disables interrupts, and continues fetching at location 0x010.
- R7: While interrupts are disabled, a pending request stays pending and the saved context is not overwritten. The request is taken right after the handler returns.
- R8: Code 0xF restores the saved program counter and accumulator and re-enables interrupts.
- R9: Code 0x0 halts the block. Once halted, halted stays high, no write occurs, and the memory address does not change until reset.
- R10: Any code other than 0x0, 0x1, 0x2, 0x5 and 0xF leaves the accumulator and memory unchanged, and execution continues with the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| mem_addr | output | 12 | Memory location (address register) |
| mem_wdata | output | 16 | Write data (buffer register) |
| mem_we | output | 1 | Memory write enable |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The assertions check five relations on every cycle:
- the fetch address matches the program counter;
- the write data matches the accumulator during a write;
- disabling interrupts coincides with a jump to the handler location;
- a deferred request is never lost and the shadow context is never overwritten while interrupts are off;
- a halt is permanent.

The bench scenarios show what only a whole program can reveal: the arithmetic results, wrap-around, unknown codes acting as no-ops, correct restoration of the accumulator across a handler that clobbers it, and a second request raised inside the handler being served exactly once after the return.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
   typedef enum logic [3:0] {
      ST_FADDR, ST_FMEM, ST_FCAP, ST_DECODE,
      ST_EADDR, ST_EMEM, ST_ECAP, ST_EXEC,
      ST_ICHK, ST_STOP
   } cyc_t;

   localparam logic [3:0] OPC_HALT  = 4'h0;
   localparam logic [3:0] OPC_LOAD  = 4'h1;
   localparam logic [3:0] OPC_STORE = 4'h2;
   localparam logic [3:0] OPC_ADD   = 4'h5;
   localparam logic [3:0] OPC_RETI  = 4'hF;

   function automatic logic uses_mem(input logic [3:0] op);
      return (op == OPC_LOAD) || (op == OPC_ADD) || (op == OPC_STORE);
   endfunction
endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
   import acc_cpu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] opcode,
   output cyc_t       state
);
   cyc_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_FADDR:  nxt = ST_FMEM;
         ST_FMEM:   nxt = ST_FCAP;
         ST_FCAP:   nxt = ST_DECODE;
         ST_DECODE: nxt = ST_EADDR;
         ST_EADDR: begin
            if (opcode == OPC_HALT)  nxt = ST_STOP;
            else if (uses_mem(opcode)) nxt = ST_EMEM;
            else                     nxt = ST_ICHK;
         end
         ST_EMEM:   nxt = (opcode == OPC_STORE) ? ST_ICHK : ST_ECAP;
         ST_ECAP:   nxt = ST_EXEC;
         ST_EXEC:   nxt = ST_ICHK;
         ST_ICHK:   nxt = ST_FADDR;
         ST_STOP:   nxt = ST_STOP;
         default:   nxt = ST_FADDR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_FADDR;
      else        state <= nxt;
   end
endmodule

// File: rtl/acc_cpu_irq.sv
module acc_cpu_irq
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 12,
   parameter bit EDGE_MODE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq,
   input  cyc_t              state,
   input  logic [3:0]        opcode,
   input  logic [ADDR_W-1:0] pc,
   input  logic [DATA_W-1:0] ac,
   output logic              take,
   output logic              ie,
   output logic [ADDR_W-1:0] saved_pc,
   output logic [DATA_W-1:0] saved_ac
);
   logic req;
   logic pending_q;

   generate
      if (EDGE_MODE) begin : g_edge
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq;
         end
         assign req = irq & ~irq_q;
      end else begin : g_level
         assign req = irq;
      end
   endgenerate

   assign take = (state == ST_ICHK) && pending_q && ie;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
         ie        <= 1'b1;
         saved_pc  <= '0;
         saved_ac  <= '0;
      end else begin
         pending_q <= (pending_q & ~take) | req;
         if (take) begin
            ie       <= 1'b0;
            saved_pc <= pc;
            saved_ac <= ac;
         end else if (state == ST_EADDR && opcode == OPC_RETI) begin
            ie <= 1'b1;
         end
      end
   end

   p_hold_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q && !ie) |=> pending_q);
   p_no_nest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ICHK && !ie) |=> ($stable(saved_pc) && $stable(saved_ac)));
endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
   import acc_cpu_pkg::*;
#(
   parameter int                 DATA_W  = 16,
   parameter int                 OP_W    = 4,
   parameter int                 ADDR_W  = 12,
   parameter logic [ADDR_W-1:0]  HANDLER = 12'h010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_t              state,
   input  logic              take,
   input  logic [ADDR_W-1:0] saved_pc,
   input  logic [DATA_W-1:0] saved_ac,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [OP_W-1:0]   opcode,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] mar,
   output logic [DATA_W-1:0] mbr,
   output logic [DATA_W-1:0] ac
);
   logic [DATA_W-1:0] ir;

   assign opcode = ir[DATA_W-1 -: OP_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc  <= '0;
         ir  <= '0;
         mar <= '0;
         mbr <= '0;
         ac  <= '0;
      end else begin
         unique case (state)
            ST_FADDR:  mar <= pc;
            ST_FCAP:   mbr <= mem_rdata;
            ST_DECODE: begin
               ir <= mbr;
               pc <= pc + ADDR_W'(1);
            end
            ST_EADDR: begin
               if (uses_mem(opcode)) mar <= ir[ADDR_W-1:0];
               if (opcode == OPC_STORE) mbr <= ac;
               if (opcode == OPC_RETI) begin
                  pc <= saved_pc;
                  ac <= saved_ac;
               end
            end
            ST_ECAP:   mbr <= mem_rdata;
            ST_EXEC: begin
               if (opcode == OPC_LOAD)     ac <= mbr;
               else if (opcode == OPC_ADD) ac <= ac + mbr;
            end
            ST_ICHK:   if (take) pc <= HANDLER;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int  DATA_W       = 16,
   parameter int  OP_W         = 4,
   parameter int  HANDLER_LOC  = 16,
   parameter bit  IRQ_EDGE     = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   irq,
   input  logic [DATA_W-1:0]      mem_rdata,
   output logic [DATA_W-OP_W-1:0] mem_addr,
   output logic [DATA_W-1:0]      mem_wdata,
   output logic                   mem_we,
   output logic                   halted
);
   localparam int ADDR_W = DATA_W - OP_W;
   localparam logic [ADDR_W-1:0] HANDLER = ADDR_W'(HANDLER_LOC);

   generate
      if (OP_W != 4) begin : g_bad_op
         $error("acc_cpu: operation code field must be 4 bits");
      end
      if (DATA_W <= OP_W + 1) begin : g_bad_w
         $error("acc_cpu: word too narrow for an address field");
      end
      if (HANDLER_LOC >= (1 << ADDR_W)) begin : g_bad_h
         $error("acc_cpu: handler location outside address space");
      end
   endgenerate

   cyc_t              state;
   logic [OP_W-1:0]   opcode;
   logic [ADDR_W-1:0] pc, mar, saved_pc;
   logic [DATA_W-1:0] mbr, ac, saved_ac;
   logic              take, ie;

   acc_cpu_seq u_seq (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .state(state)
   );

   acc_cpu_datapath #(
      .DATA_W(DATA_W), .OP_W(OP_W), .ADDR_W(ADDR_W), .HANDLER(HANDLER)
   ) u_dp (
      .clk(clk), .rst_n(rst_n), .state(state), .take(take),
      .saved_pc(saved_pc), .saved_ac(saved_ac), .mem_rdata(mem_rdata),
      .opcode(opcode), .pc(pc), .mar(mar), .mbr(mbr), .ac(ac)
   );

   acc_cpu_irq #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EDGE_MODE(IRQ_EDGE)
   ) u_irq (
      .clk(clk), .rst_n(rst_n), .irq(irq), .state(state), .opcode(opcode),
      .pc(pc), .ac(ac), .take(take), .ie(ie),
      .saved_pc(saved_pc), .saved_ac(saved_ac)
   );

   assign mem_addr  = mar;
   assign mem_wdata = mbr;
   assign mem_we    = (state == ST_EMEM) && (opcode == OPC_STORE);
   assign halted    = (state == ST_STOP);

   p_fetch_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FMEM) |-> (mem_addr == pc));
   p_wdata_ac_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata == ac));
   p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ie) |-> (pc == HANDLER));
   p_reti_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EADDR && opcode == OPC_RETI) |=> ie);
   p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && !mem_we && $stable(mem_addr)));
endmodule

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq = 1'b0;
   logic [15:0] mem_rdata;
   logic [11:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_we;
   logic        halted;

   logic        ld_en = 1'b0;
   logic [7:0]  ld_addr = '0;
   logic [15:0] ld_data = '0;
   logic [15:0] mem [256];

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   bit saw_handler = 1'b0;

   always #4 clk = ~clk;

   acc_cpu u0 (
      .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .halted(halted)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (ld_en)       mem[ld_addr] <= ld_data;
      else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
      if (rst_n && mem_addr == 12'h010) saw_handler <= 1'b1;
   end

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      while (cycles < 150000) @(negedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not end");
      finish_run();
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic poke(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      ld_en = 1'b1; ld_addr = a; ld_data = d;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic clear_mem();
      rst_n = 1'b0;
      for (int i = 0; i < 256; i++) poke(8'(i), 16'h0000);
   endtask

   task automatic run_until_halt(input int limit);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < limit && !halted; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      clear_mem();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!halted && !mem_we, "R1 reset halted/we", {halted, mem_we}, 0);
      check(mem_addr == 12'h000, "R1 first fetch location", mem_addr, 0);
      rst_n = 1'b0;
   endtask

   task automatic t_basic();
      clear_mem();
      poke(8'h00, 16'h1040); poke(8'h01, 16'h5041);
      poke(8'h02, 16'h2042); poke(8'h03, 16'h0000);
      poke(8'h40, 16'h1234); poke(8'h41, 16'h1111);
      run_until_halt(500);
      check(halted, "R9 halt reached", halted, 1);
      check(mem[8'h42] == 16'h2345, "R2 R3 R4 load add store", mem[8'h42], 16'h2345);
      check(mem[8'h40] == 16'h1234, "R4 source intact", mem[8'h40], 16'h1234);
   endtask

   task automatic t_wrap();
      clear_mem();
      poke(8'h00, 16'h1040); poke(8'h01, 16'h5041);
      poke(8'h02, 16'h2043); poke(8'h03, 16'h1042);
      poke(8'h04, 16'h2044); poke(8'h05, 16'h0000);
      poke(8'h40, 16'hFFFF); poke(8'h41, 16'h0003); poke(8'h42, 16'hBEEF);
      run_until_halt(500);
      check(mem[8'h43] == 16'h0002, "R3 wrap sum", mem[8'h43], 16'h0002);
      check(mem[8'h44] == 16'hBEEF, "R5 sequential second load", mem[8'h44], 16'hBEEF);
   endtask

   task automatic t_nop();
      clear_mem();
      poke(8'h00, 16'h1040); poke(8'h01, 16'h3041); poke(8'h02, 16'h7041);
      poke(8'h03, 16'hC041); poke(8'h04, 16'h2042); poke(8'h05, 16'h0000);
      poke(8'h40, 16'h00A5); poke(8'h41, 16'h0F0F);
      run_until_halt(500);
      check(mem[8'h42] == 16'h00A5, "R10 unknown codes keep AC", mem[8'h42], 16'h00A5);
      check(mem[8'h41] == 16'h0F0F, "R10 unknown codes no write", mem[8'h41], 16'h0F0F);
   endtask

   task automatic load_irq_prog();
      clear_mem();
      poke(8'h00, 16'h1040); poke(8'h01, 16'h5041); poke(8'h02, 16'h5041);
      poke(8'h03, 16'h2042); poke(8'h04, 16'h0000);
      poke(8'h10, 16'h1060); poke(8'h11, 16'h5061);
      poke(8'h12, 16'h2060); poke(8'h13, 16'hF000);
      poke(8'h40, 16'h0100); poke(8'h41, 16'h0023);
      poke(8'h60, 16'h0000); poke(8'h61, 16'h0001);
   endtask

   task automatic t_irq_once();
      load_irq_prog();
      @(negedge clk);
      saw_handler = 1'b0;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      irq = 1'b1; @(negedge clk); irq = 1'b0;
      for (int i = 0; i < 1000 && !halted; i++) @(negedge clk);
      check(saw_handler, "R6 handler location fetched", saw_handler, 1);
      check(mem[8'h60] == 16'h0001, "R6 handler ran once", mem[8'h60], 1);
      check(mem[8'h42] == 16'h0146, "R8 AC and PC restored", mem[8'h42], 16'h0146);
   endtask

   task automatic t_irq_deferred();
      load_irq_prog();
      @(negedge clk);
      saw_handler = 1'b0;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      irq = 1'b1; @(negedge clk); irq = 1'b0;
      for (int i = 0; i < 200 && !saw_handler; i++) @(negedge clk);
      repeat (6) @(negedge clk);
      irq = 1'b1; @(negedge clk); irq = 1'b0;
      for (int i = 0; i < 1000 && !halted; i++) @(negedge clk);
      check(mem[8'h60] == 16'h0002, "R7 deferred request served once", mem[8'h60], 2);
      check(mem[8'h42] == 16'h0146, "R7 main result intact", mem[8'h42], 16'h0146);
   endtask

   task automatic t_halt_hold();
      logic [11:0] a0;
      bit bad;
      clear_mem();
      poke(8'h00, 16'h1040); poke(8'h01, 16'h0000); poke(8'h02, 16'h2041);
      poke(8'h40, 16'h5555);
      run_until_halt(500);
      a0 = mem_addr;
      bad = 1'b0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (mem_we || mem_addr != a0 || !halted) bad = 1'b1;
      end
      check(!bad, "R9 halt holds", bad, 0);
      check(mem[8'h41] == 16'h0000, "R9 no store after halt", mem[8'h41], 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_basic();
      t_wrap();
      t_nop();
      t_irq_once();
      t_irq_deferred();
      t_halt_hold();
      finish_run();
   end
endmodule